// File: doc/BRIEF.md
# Dual-Channel Disk Controller Address Decoder

This block sits between a host programmed-I/O port and the register ports of up to four disk drives on two legacy channels. Every host access is compared against five address windows: command block and control block for each channel, plus one bus-master register block. The decoder reports which window was hit, which channel it belongs to and the offset inside the window. It then forwards the access to the bus-master register port, or to the register port of the drive that the channel currently selects.

Each channel tracks which of its two drives is addressed. It does this by watching host writes to the drive/head select register. A 32-bit access to a data register becomes two back-to-back 16-bit drive transfers. A small configuration write port moves the window bases and sets the I/O-decode and bus-master enables. Accesses that hit no window or use an illegal width are rejected with an error pulse. Accesses made while decode is off complete quietly.

Top module: `pio_window_decoder`

## Requirements
- R1: After reset the block is ready (`hostReady`=1), `hostDone`, `hostErr`, `drvReq` and `bmReq` are 0, and both enables are 0.
- R2: Windows are checked in fixed priority: primary command (size 8), primary control (size 4), secondary command (size 8), secondary control (size 4), bus-master (size 16). The first hit wins. `offsetOut` = address − base. `regClass` is 0 = none, 1 = command, 2 = control, 3 = bus-master. `chanOut` is 0 = primary, 1 = secondary.
- R3: In the bus-master window, offsets below 8 belong to channel 0 and offsets 8 and up belong to channel 1. A hit produces one `bmReq` cycle; the read data is `bmRdata` masked to the access size.
- R4: A byte write at command-block offset 6 latches data bit 4 as that channel's device bit (0 = master, 1 = slave) and is still forwarded to the drive. `drvIdx` = 2·channel + device bit.
- R5: While I/O decode is off, an access completes one cycle after acceptance. It has no error, no drive or bus-master strobe, zero read data and no change to any device bit.
- R6: A drive access lasts one `drvReq` cycle and completes on the next cycle. A 32-bit access makes two `drvReq` cycles, low half then high half, and completes on the cycle after. Read data is assembled low/high.
- R7: Size codes are 0 = byte, 1 = word, 2 = doubleword, 3 = illegal. Command-block offset 0 (data) accepts word or doubleword. All other command/control offsets accept byte only. The bus-master window accepts codes 0 to 2. A violation gives `hostErr` together with `hostDone` and no strobe.
- R8: An access that hits no window gives `hostErr` with `hostDone` and `regClass` 0.
- R9: Configuration selects 0 to 4 write the five window bases in priority order. A zero value leaves the base unchanged.
- R10: A write to configuration select 5 sets the I/O enable from data bit 0 and the bus-master enable from data bit 2.
- R11: An access to a drive whose `drvPresent` bit is 0 completes one cycle after acceptance, with no `drvReq`, no error and zero read data.
- R12: A bus-master write while the bus-master enable is 0 is dropped: no `bmReq`, no error. Bus-master reads are still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | 0-4 window base, 5 enable flags |
| cfgData | input | ADDR_W | Configuration write data |
| hostReq | input | 1 | One-cycle access request, honoured when ready |
| hostWr | input | 1 | 1 = write |
| hostAddr | input | ADDR_W | Access address |
| hostSize | input | 2 | Access size code |
| hostWdata | input | 32 | Write data |
| hostReady | output | 1 | Idle, a request may be issued |
| hostDone | output | 1 | Access complete pulse |
| hostErr | output | 1 | Rejected access, with hostDone |
| hostRdata | output | 32 | Read data, valid with hostDone |
| ioEnable | output | 1 | I/O decode enable |
| bmEnable | output | 1 | Bus-master enable |
| regClass | output | 2 | Decoded window class of the last access |
| chanOut | output | 1 | Decoded channel of the last access |
| offsetOut | output | OFF_W | Offset inside the window |
| accSize | output | 2 | Size code of the last access |
| drvReq | output | 1 | Drive register transfer strobe |
| drvWr | output | 1 | Drive transfer is a write |
| drvIdx | output | 2 | Target drive index |
| drvIsCtrl | output | 1 | Transfer targets the control block |
| drvWdata | output | 16 | Drive write data half |
| drvRdata | input | 16 | Drive read data, same cycle |
| drvPresent | input | 4 | Drive present map, bit per index |
| bmReq | output | 1 | Bus-master register strobe |
| bmWr | output | 1 | Bus-master access is a write |
| bmWdata | output | 32 | Bus-master write data |
| bmRdata | input | 32 | Bus-master read data, same cycle |

## Verification
The hardest case to reach is the interplay of window priority with a movable bus-master base. It only shows up once a base has been moved on top of another window. The stimulus reprograms the bus-master base onto the primary command range: the first eight addresses must still decode as command registers, and the next eight must fall into the secondary half of the bus-master block. A second hard case is proving that a select write reached an absent drive's channel. The bench does this through later accesses whose drive index or missing strobe depends on the latched device bit.

// File: rtl/piodec_pkg.sv
package piodec_pkg;
  localparam int NUM_WIN     = 5;
  localparam int CFG_CMD_SEL = 5;
  localparam int DATA_OFF    = 0;
  localparam int SEL_OFF     = 6;
  localparam int DEV_BIT     = 4;
  localparam int IOEN_BIT    = 0;
  localparam int BMEN_BIT    = 2;

  localparam logic [1:0] RC_NONE = 2'd0;
  localparam logic [1:0] RC_CMD  = 2'd1;
  localparam logic [1:0] RC_CTRL = 2'd2;
  localparam logic [1:0] RC_BM   = 2'd3;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;
  localparam logic [1:0] SZ_BAD   = 2'd3;

  typedef struct packed {
    logic accept;
    logic capLo;
    logic capHi;
    logic capBm;
  } strobe_t;
endpackage

// File: rtl/piodec_dp.sv
module piodec_dp
  import piodec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 4,
  parameter int CMD_SIZE   = 8,
  parameter int CTRL_SIZE  = 4,
  parameter int BM_SIZE    = 16,
  parameter int BM_SEC_OFF = 8,
  parameter logic [ADDR_W-1:0] PRI_CMD_RST  = 16'h01F0,
  parameter logic [ADDR_W-1:0] PRI_CTRL_RST = 16'h03F4,
  parameter logic [ADDR_W-1:0] SEC_CMD_RST  = 16'h0170,
  parameter logic [ADDR_W-1:0] SEC_CTRL_RST = 16'h0374,
  parameter logic [ADDR_W-1:0] BM_RST       = 16'hC000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  input  strobe_t           stb,
  output logic              reqHit,
  output logic              reqLegal,
  output logic              reqIsBm,
  output logic              reqPresent,
  output logic              ioEnable,
  output logic              bmEnable,
  output logic [1:0]        regClass,
  output logic              chanOut,
  output logic [OFF_W-1:0]  offsetOut,
  output logic [1:0]        accSize,
  output logic              drvWr,
  output logic [1:0]        drvIdx,
  output logic              drvIsCtrl,
  output logic [15:0]       drvWdata,
  input  logic [15:0]       drvRdata,
  input  logic [3:0]        drvPresent,
  output logic [31:0]       bmWdata,
  input  logic [31:0]       bmRdata,
  output logic [31:0]       hostRdata
);
  localparam int SUM_W = ADDR_W + 1;

  function automatic int winSize(input int w);
    case (w)
      0, 2:    return CMD_SIZE;
      1, 3:    return CTRL_SIZE;
      default: return BM_SIZE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] winReset(input int w);
    case (w)
      0:       return PRI_CMD_RST;
      1:       return PRI_CTRL_RST;
      2:       return SEC_CMD_RST;
      3:       return SEC_CTRL_RST;
      default: return BM_RST;
    endcase
  endfunction

  logic [ADDR_W-1:0]  baseArr [NUM_WIN];
  logic [NUM_WIN-1:0] winHit;

  // one comparator and one base register per window
  for (genvar gw = 0; gw < NUM_WIN; gw++) begin : g_win
    localparam logic [SUM_W-1:0] WSZ = SUM_W'(winSize(gw));
    logic [ADDR_W-1:0] baseQ;
    logic [SUM_W-1:0]  limit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        baseQ <= winReset(gw);
      else if (cfgWrEn && cfgSel == 3'(gw) && cfgData != '0)
        baseQ <= cfgData;
    end

    assign limit       = {1'b0, baseQ} + WSZ;
    assign winHit[gw]  = ({1'b0, hostAddr} >= {1'b0, baseQ}) &&
                         ({1'b0, hostAddr} < limit);
    assign baseArr[gw] = baseQ;

    assert_base_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && cfgSel == 3'(gw) && cfgData == '0) |=> $stable(baseQ));
  end

  // priority pick: lowest window index wins
  logic [2:0]        winSel;
  logic [ADDR_W-1:0] selBase;
  logic              anyHit;
  always_comb begin
    winSel  = '0;
    selBase = baseArr[0];
    anyHit  = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (winHit[w]) begin
        winSel  = 3'(w);
        selBase = baseArr[w];
        anyHit  = 1'b1;
      end
    end
  end

  logic [ADDR_W-1:0] rawOff;
  logic [OFF_W-1:0]  curOff;
  logic [1:0]        curCls;
  logic              curChan;
  assign rawOff = hostAddr - selBase;
  assign curOff = rawOff[OFF_W-1:0];

  always_comb begin
    curCls  = RC_NONE;
    curChan = 1'b0;
    if (anyHit) begin
      case (winSel)
        3'd0:    begin curCls = RC_CMD;  curChan = 1'b0; end
        3'd1:    begin curCls = RC_CTRL; curChan = 1'b0; end
        3'd2:    begin curCls = RC_CMD;  curChan = 1'b1; end
        3'd3:    begin curCls = RC_CTRL; curChan = 1'b1; end
        default: begin
          curCls  = RC_BM;
          curChan = (curOff >= OFF_W'(BM_SEC_OFF));
        end
      endcase
    end
  end

  logic isDataReg;
  assign isDataReg = (curCls == RC_CMD) && (curOff == OFF_W'(DATA_OFF));

  always_comb begin
    case (curCls)
      RC_BM:        reqLegal = (hostSize != SZ_BAD);
      RC_CMD,
      RC_CTRL:      reqLegal = isDataReg ? (hostSize == SZ_WORD || hostSize == SZ_DWORD)
                                         : (hostSize == SZ_BYTE);
      default:      reqLegal = 1'b0;
    endcase
  end

  assign reqHit  = anyHit;
  assign reqIsBm = (curCls == RC_BM);

  // device-select snoop
  logic [1:0] devSelQ;
  logic       selWrite;
  logic       nextDev;
  logic [1:0] idxNow;
  logic       ioEnQ, bmEnQ;

  assign selWrite = ioEnQ && anyHit && reqLegal && hostWr &&
                    (curCls == RC_CMD) && (curOff == OFF_W'(SEL_OFF));
  assign nextDev  = selWrite ? hostWdata[DEV_BIT] : devSelQ[curChan];
  assign idxNow   = {curChan, nextDev};
  assign reqPresent = drvPresent[idxNow];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      devSelQ <= '0;
    else if (stb.accept && selWrite)
      devSelQ[curChan] <= hostWdata[DEV_BIT];
  end

  assert_devsel_src_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(devSelQ) |-> $past(stb.accept && hostWr));

  // enable flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioEnQ <= 1'b0;
      bmEnQ <= 1'b0;
    end else if (cfgWrEn && cfgSel == 3'(CFG_CMD_SEL)) begin
      ioEnQ <= cfgData[IOEN_BIT];
      bmEnQ <= cfgData[BMEN_BIT];
    end
  end
  assign ioEnable = ioEnQ;
  assign bmEnable = bmEnQ;

  // request capture
  logic [1:0]       clsQ, sizeQ, idxQ;
  logic             chanQ, wrQ;
  logic [OFF_W-1:0] offQ;
  logic [31:0]      wdataQ, rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clsQ   <= RC_NONE;
      sizeQ  <= SZ_BYTE;
      idxQ   <= '0;
      chanQ  <= 1'b0;
      wrQ    <= 1'b0;
      offQ   <= '0;
      wdataQ <= '0;
    end else if (stb.accept) begin
      clsQ   <= curCls;
      sizeQ  <= hostSize;
      idxQ   <= idxNow;
      chanQ  <= curChan;
      wrQ    <= hostWr;
      offQ   <= curOff;
      wdataQ <= hostWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdQ <= '0;
    else if (stb.accept)
      rdQ <= '0;
    else if (stb.capLo && !wrQ)
      rdQ[15:0] <= (sizeQ == SZ_BYTE) ? {8'h00, drvRdata[7:0]} : drvRdata;
    else if (stb.capHi && !wrQ)
      rdQ[31:16] <= drvRdata;
    else if (stb.capBm && !wrQ) begin
      case (sizeQ)
        SZ_BYTE: rdQ <= {24'h0, bmRdata[7:0]};
        SZ_WORD: rdQ <= {16'h0, bmRdata[15:0]};
        default: rdQ <= bmRdata;
      endcase
    end
  end

  assign regClass  = clsQ;
  assign chanOut   = chanQ;
  assign offsetOut = offQ;
  assign accSize   = sizeQ;
  assign drvWr     = wrQ;
  assign drvIdx    = idxQ;
  assign drvIsCtrl = (clsQ == RC_CTRL);
  assign drvWdata  = stb.capHi ? wdataQ[31:16] : wdataQ[15:0];
  assign bmWdata   = wdataQ;
  assign hostRdata = rdQ;
endmodule

// File: rtl/piodec_ctrl.sv
module piodec_ctrl
  import piodec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       hostWr,
  input  logic [1:0] hostSize,
  input  logic       reqHit,
  input  logic       reqLegal,
  input  logic       reqIsBm,
  input  logic       reqPresent,
  input  logic       ioEnable,
  input  logic       bmEnable,
  output strobe_t    stb,
  output logic       hostReady,
  output logic       hostDone,
  output logic       hostErr,
  output logic       drvReq,
  output logic       bmReq
);
  typedef enum logic [2:0] {ST_IDLE, ST_LO, ST_HI, ST_BM, ST_FIN} state_e;

  state_e stateQ, stateD;
  logic   dwordQ, errQ, errD;

  assign stb.accept = (stateQ == ST_IDLE) && hostReq;
  assign stb.capLo  = (stateQ == ST_LO);
  assign stb.capHi  = (stateQ == ST_HI);
  assign stb.capBm  = (stateQ == ST_BM);

  always_comb begin
    stateD = stateQ;
    errD   = errQ;
    case (stateQ)
      ST_IDLE: if (hostReq) begin
        errD = 1'b0;
        if (!ioEnable)
          stateD = ST_FIN;
        else if (!reqHit || !reqLegal) begin
          stateD = ST_FIN;
          errD   = 1'b1;
        end else if (reqIsBm)
          stateD = (hostWr && !bmEnable) ? ST_FIN : ST_BM;
        else if (!reqPresent)
          stateD = ST_FIN;
        else
          stateD = ST_LO;
      end
      ST_LO:   stateD = dwordQ ? ST_HI : ST_FIN;
      ST_HI:   stateD = ST_FIN;
      ST_BM:   stateD = ST_FIN;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      dwordQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
      if (stb.accept) dwordQ <= (hostSize == SZ_DWORD);
    end
  end

  assign hostReady = (stateQ == ST_IDLE);
  assign hostDone  = (stateQ == ST_FIN);
  assign hostErr   = (stateQ == ST_FIN) && errQ;
  assign drvReq    = (stateQ == ST_LO) || (stateQ == ST_HI);
  assign bmReq     = (stateQ == ST_BM);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drvReq, bmReq, hostDone}));

  assert_dword_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    (drvReq && !stb.capHi && dwordQ) |=> (drvReq && stb.capHi));

  assert_err_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> hostDone);

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && !ioEnable) |=> (hostDone && !hostErr && !drvReq && !bmReq));

  assert_miss_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && ioEnable && !reqHit) |=> hostErr);

  assert_bm_drop_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && ioEnable && reqHit && reqLegal && reqIsBm && hostWr && !bmEnable)
      |=> (hostDone && !bmReq && !hostErr));
endmodule

// File: rtl/pio_window_decoder.sv
module pio_window_decoder
  import piodec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CMD_SIZE   = 8,
  parameter int CTRL_SIZE  = 4,
  parameter int BM_SIZE    = 16,
  parameter int BM_SEC_OFF = 8,
  parameter int OFF_W      = $clog2(BM_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  output logic              hostReady,
  output logic              hostDone,
  output logic              hostErr,
  output logic [31:0]       hostRdata,
  output logic              ioEnable,
  output logic              bmEnable,
  output logic [1:0]        regClass,
  output logic              chanOut,
  output logic [OFF_W-1:0]  offsetOut,
  output logic [1:0]        accSize,
  output logic              drvReq,
  output logic              drvWr,
  output logic [1:0]        drvIdx,
  output logic              drvIsCtrl,
  output logic [15:0]       drvWdata,
  input  logic [15:0]       drvRdata,
  input  logic [3:0]        drvPresent,
  output logic              bmReq,
  output logic              bmWr,
  output logic [31:0]       bmWdata,
  input  logic [31:0]       bmRdata
);
  strobe_t stb;
  logic reqHit, reqLegal, reqIsBm, reqPresent;

  piodec_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .hostWr    (hostWr),
    .hostSize  (hostSize),
    .reqHit    (reqHit),
    .reqLegal  (reqLegal),
    .reqIsBm   (reqIsBm),
    .reqPresent(reqPresent),
    .ioEnable  (ioEnable),
    .bmEnable  (bmEnable),
    .stb       (stb),
    .hostReady (hostReady),
    .hostDone  (hostDone),
    .hostErr   (hostErr),
    .drvReq    (drvReq),
    .bmReq     (bmReq)
  );

  piodec_dp #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .CMD_SIZE  (CMD_SIZE),
    .CTRL_SIZE (CTRL_SIZE),
    .BM_SIZE   (BM_SIZE),
    .BM_SEC_OFF(BM_SEC_OFF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .hostSize  (hostSize),
    .hostWdata (hostWdata),
    .stb       (stb),
    .reqHit    (reqHit),
    .reqLegal  (reqLegal),
    .reqIsBm   (reqIsBm),
    .reqPresent(reqPresent),
    .ioEnable  (ioEnable),
    .bmEnable  (bmEnable),
    .regClass  (regClass),
    .chanOut   (chanOut),
    .offsetOut (offsetOut),
    .accSize   (accSize),
    .drvWr     (drvWr),
    .drvIdx    (drvIdx),
    .drvIsCtrl (drvIsCtrl),
    .drvWdata  (drvWdata),
    .drvRdata  (drvRdata),
    .drvPresent(drvPresent),
    .bmWdata   (bmWdata),
    .bmRdata   (bmRdata),
    .hostRdata (hostRdata)
  );

  assign bmWr = drvWr;
endmodule

// File: tb/pio_window_decoder_tb.sv
module pio_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [15:0] cfgData = '0;
  logic        hostReq = 1'b0, hostWr = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic        hostReady, hostDone, hostErr;
  logic [31:0] hostRdata;
  logic        ioEnable, bmEnable;
  logic [1:0]  regClass;
  logic        chanOut;
  logic [3:0]  offsetOut;
  logic [1:0]  accSize;
  logic        drvReq, drvWr, drvIsCtrl;
  logic [1:0]  drvIdx;
  logic [15:0] drvWdata, drvRdata;
  logic [3:0]  drvPresent = 4'b1111;
  logic        bmReq, bmWr;
  logic [31:0] bmWdata;
  logic [31:0] bmRdata = 32'h1234_5678;

  always #4 clk = ~clk;

  // drive model: first transfer of an access returns loVal, later ones hiVal
  localparam logic [15:0] LO_VAL = 16'h5A3C;
  localparam logic [15:0] HI_VAL = 16'hC3A5;
  int xferCnt = 0;
  int xferMark = 0;
  always @(posedge clk) if (drvReq) xferCnt <= xferCnt + 1;
  assign drvRdata = (xferCnt == xferMark) ? LO_VAL : HI_VAL;

  pio_window_decoder u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .hostReq(hostReq), .hostWr(hostWr), .hostAddr(hostAddr), .hostSize(hostSize),
    .hostWdata(hostWdata), .hostReady(hostReady), .hostDone(hostDone), .hostErr(hostErr),
    .hostRdata(hostRdata), .ioEnable(ioEnable), .bmEnable(bmEnable), .regClass(regClass),
    .chanOut(chanOut), .offsetOut(offsetOut), .accSize(accSize), .drvReq(drvReq),
    .drvWr(drvWr), .drvIdx(drvIdx), .drvIsCtrl(drvIsCtrl), .drvWdata(drvWdata),
    .drvRdata(drvRdata), .drvPresent(drvPresent), .bmReq(bmReq), .bmWr(bmWr),
    .bmWdata(bmWdata), .bmRdata(bmRdata)
  );

  int vectors = 0;
  int fails = 0;

  // observations of the last access
  int          doneK, nDrv, nBm;
  logic        errSeen, drvWrA, drvCtrlA, bmWrSeen;
  logic [31:0] rdSeen;
  logic [1:0]  idxA [2];
  logic [15:0] wdA [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    hostReq = 1'b1; hostWr = wr; hostAddr = a; hostSize = sz; hostWdata = wd;
    xferMark = xferCnt;
    doneK = 0; nDrv = 0; nBm = 0; errSeen = 1'b0; rdSeen = '0;
    @(negedge clk);
    hostReq = 1'b0;
    for (int k = 1; k <= 8 && doneK == 0; k++) begin
      if (drvReq) begin
        if (nDrv < 2) begin idxA[nDrv] = drvIdx; wdA[nDrv] = drvWdata; end
        drvWrA = drvWr; drvCtrlA = drvIsCtrl; nDrv++;
      end
      if (bmReq) begin nBm++; bmWrSeen = bmWr; end
      if (hostDone) begin
        doneK = k; errSeen = hostErr; rdSeen = hostRdata;
      end else @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ready", 32'(hostReady), 1);
    chk("R1 done", 32'(hostDone), 0);
    chk("R1 err", 32'(hostErr), 0);
    chk("R1 strobes", 32'({drvReq, bmReq}), 0);
    chk("R1 enables", 32'({ioEnable, bmEnable}), 0);
  endtask

  task automatic t_disabled;
    access(1'b1, 16'h01F6, 2'd0, 32'h10);   // would select slave if enabled
    chk("R5 done cycle", doneK, 1);
    chk("R5 no err", 32'(errSeen), 0);
    chk("R5 no drive strobe", nDrv, 0);
    access(1'b0, 16'hC000, 2'd2, 0);
    chk("R5 no bm strobe", nBm, 0);
    chk("R5 rdata zero", rdSeen, 0);
  endtask

  task automatic t_flags;
    cfg(3'd5, 16'h0001);
    chk("R10 io on", 32'(ioEnable), 1);
    chk("R10 bm off", 32'(bmEnable), 0);
  endtask

  task automatic t_data_word;
    access(1'b0, 16'h01F0, 2'd1, 0);
    chk("R6 word done cycle", doneK, 2);
    chk("R6 word one xfer", nDrv, 1);
    chk("R5 devsel untouched", 32'(idxA[0]), 0);
    chk("R6 word rdata", rdSeen, 32'h0000_5A3C);
    chk("R2 class cmd", 32'(regClass), 1);
    chk("R2 chan pri", 32'(chanOut), 0);
    chk("R2 offset 0", 32'(offsetOut), 0);
  endtask

  task automatic t_select;
    access(1'b1, 16'h0176, 2'd0, 32'h0000_0010);
    chk("R4 select forwarded", nDrv, 1);
    chk("R4 select to slave idx", 32'(idxA[0]), 3);
    chk("R4 select is write", 32'(drvWrA), 1);
    chk("R2 select offset", 32'(offsetOut), 6);
    chk("R2 select chan", 32'(chanOut), 1);
    access(1'b0, 16'h0177, 2'd0, 0);
    chk("R4 next access idx", 32'(idxA[0]), 3);
    chk("R4 byte rdata mask", rdSeen, 32'h0000_003C);
  endtask

  task automatic t_dword;
    access(1'b1, 16'h01F0, 2'd2, 32'hDEAD_BEEF);
    chk("R6 dword done cycle", doneK, 3);
    chk("R6 dword two xfers", nDrv, 2);
    chk("R6 low half first", 32'(wdA[0]), 32'h0000_BEEF);
    chk("R6 high half second", 32'(wdA[1]), 32'h0000_DEAD);
    access(1'b0, 16'h01F0, 2'd2, 0);
    chk("R6 dword rdata", rdSeen, 32'hC3A5_5A3C);
  endtask

  task automatic t_illegal;
    access(1'b0, 16'h01F0, 2'd0, 0);
    chk("R7 byte on data err", 32'(errSeen), 1);
    chk("R7 err done cycle", doneK, 1);
    chk("R7 no xfer", nDrv, 0);
    access(1'b0, 16'h01F1, 2'd1, 0);
    chk("R7 word on reg err", 32'(errSeen), 1);
    access(1'b0, 16'hC000, 2'd3, 0);
    chk("R7 bad code on bm err", 32'(errSeen), 1);
    chk("R7 bad code no bm", nBm, 0);
  endtask

  task automatic t_miss;
    access(1'b0, 16'h0000, 2'd0, 0);
    chk("R8 miss err", 32'(errSeen), 1);
    chk("R8 miss class", 32'(regClass), 0);
  endtask

  task automatic t_ctrl;
    access(1'b0, 16'h03F6, 2'd0, 0);
    chk("R2 ctrl class", 32'(regClass), 2);
    chk("R2 ctrl offset", 32'(offsetOut), 2);
    chk("R2 ctrl flag", 32'(drvCtrlA), 1);
    chk("R2 ctrl pri idx", 32'(idxA[0]), 0);
    access(1'b0, 16'h0376, 2'd0, 0);
    chk("R2 ctrl sec idx", 32'(idxA[0]), 3);
  endtask

  task automatic t_absent;
    drvPresent = 4'b1011;
    access(1'b1, 16'h0176, 2'd0, 32'h0);   // secondary back to master, drive 2 absent
    chk("R11 absent no xfer", nDrv, 0);
    chk("R11 absent done", doneK, 1);
    chk("R11 absent no err", 32'(errSeen), 0);
    access(1'b0, 16'h0170, 2'd1, 0);
    chk("R11 absent rdata", rdSeen, 0);
    chk("R11 absent read no xfer", nDrv, 0);
    drvPresent = 4'b1111;
    access(1'b0, 16'h0170, 2'd1, 0);
    chk("R4 devsel cleared idx", 32'(idxA[0]), 2);
  endtask

  task automatic t_busmaster;
    access(1'b1, 16'hC002, 2'd0, 32'h5);
    chk("R12 bm write dropped", nBm, 0);
    chk("R12 drop no err", 32'(errSeen), 0);
    access(1'b0, 16'hC00A, 2'd1, 0);
    chk("R12 bm read forwarded", nBm, 1);
    chk("R3 bm done cycle", doneK, 2);
    chk("R3 bm class", 32'(regClass), 3);
    chk("R3 bm high off chan", 32'(chanOut), 1);
    chk("R3 bm word rdata", rdSeen, 32'h0000_5678);
    access(1'b0, 16'hC004, 2'd0, 0);
    chk("R3 bm low off chan", 32'(chanOut), 0);
    chk("R3 bm byte rdata", rdSeen, 32'h0000_0078);
    cfg(3'd5, 16'h0005);
    chk("R10 bm on", 32'(bmEnable), 1);
    access(1'b1, 16'hC002, 2'd0, 32'h5);
    chk("R12 bm write enabled", nBm, 1);
    chk("R12 bm write flag", 32'(bmWrSeen), 1);
  endtask

  task automatic t_bases;
    cfg(3'd0, 16'h0000);
    access(1'b0, 16'h01F7, 2'd0, 0);
    chk("R9 zero keeps base", 32'(regClass), 1);
    chk("R9 zero keeps offset", 32'(offsetOut), 7);
    cfg(3'd4, 16'h01F0);
    access(1'b0, 16'h01F0, 2'd1, 0);
    chk("R2 priority cmd over bm", 32'(regClass), 1);
    chk("R2 priority drive xfer", nDrv, 1);
    access(1'b0, 16'h01F8, 2'd2, 0);
    chk("R3 moved bm class", 32'(regClass), 3);
    chk("R3 moved bm offset", 32'(offsetOut), 8);
    chk("R3 moved bm chan", 32'(chanOut), 1);
    chk("R3 moved bm rdata", rdSeen, 32'h1234_5678);
    cfg(3'd0, 16'h0200);
    access(1'b0, 16'h0200, 2'd1, 0);
    chk("R9 nonzero moves base", 32'(regClass), 1);
    chk("R9 moved base offset", 32'(offsetOut), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_disabled();
    t_flags();
    t_data_word();
    t_select();
    t_dword();
    t_illegal();
    t_miss();
    t_ctrl();
    t_absent();
    t_busmaster();
    t_bases();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule